// File: doc/BRIEF.md
# Multi-Channel DMA Channel Controller

This block keeps the control state for a set of DMA channels and rules on every transfer request a device makes. Each channel owns four 32-bit registers: a free mode word, a flags word (enable, direction and three status bits), a remaining byte count and a start address. A host reaches all of them through a simple 32-bit register port with combinational read data.

A device asks for a transfer by pulsing a request with a channel number, a direction and a wanted length. The controller wipes that channel's old status bits and checks that the channel is enabled and set for the same direction. If the check fails, it reports an error, grants nothing and latches a per-channel bit in a sticky error-source register. If the check passes, it grants the smaller of the wanted length and the remaining count, returns the channel's start address and lowers the count by the grant. Moving the data and translating the address are left to the neighbouring blocks.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel register and the error-source register read as zero, and rsp_valid is low.
- R2: Channel register `idx` (0 mode, 1 flags, 2 count, 3 address) of channel `c` sits at byte offset 0x100 + c*0x20 + idx*8. The channel comes from offset bits 7:5, the index from bits 4:3, and bits 2:0 are ignored. A host write stores all 32 bits, and a read returns them.
- R3: Offsets outside the channel window read as zero, and writes to them change nothing. The error-source register at offset 0x200 is read-only, with bit c for channel c.
- R4: rsp_valid is high in exactly the cycle after each cycle in which req_valid is high, and low otherwise.
- R5: Every request clears flag bits 8, 9 and 10 of its channel before setting new status. All other flag bits are kept.
- R6: A request is refused when flag bit 0 (enable) is clear or req_to_dev differs from flag bit 1 (1 = memory to device). A refused request returns rsp_err=1, rsp_len=0 and rsp_addr=0, sets flag bit 9, and leaves the count unchanged.
- R7: A refused request on channel c sets bit c of the error-source register. That bit stays set until reset.
- R8: An accepted request returns rsp_err=0, rsp_len = min(req_len, count) and rsp_addr = the address register. It sets flag bit 8, lowers the count by rsp_len, and leaves the address register unchanged.
- R9: An accepted request on a channel whose count is zero grants zero bytes but still sets flag bit 8.
- R10: If a host write hits the flags or count register of the channel being requested in the same cycle, the write is dropped. Host writes to other registers in that cycle take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| req_valid | input | 1 | Device transfer request strobe |
| req_ch | input | 3 | Requested channel |
| req_to_dev | input | 1 | Requested direction, 1 = memory to device |
| req_len | input | 16 | Wanted length in bytes |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Request refused |
| rsp_len | output | 16 | Granted length |
| rsp_addr | output | 32 | Transfer start address |

## Verification
The bench builds the block with its default parameters: eight channels and a 16-bit request length against a 32-bit count. With these values every channel number and every register offset is in reach. The random counts are kept small half of the time, so the length is clamped by the count in some requests and by the wanted length in others, and counts run down to zero. Random flag words often leave a channel disabled or set for the other direction, so refused and accepted requests mix on the same channel. This lets the bench see status bits being cleared, error-source bits building up, and writes colliding with a request.

// File: rtl/dma_cc_pkg.sv
`timescale 1ns/1ps
package dma_cc_pkg;
  localparam int DATA_W = 32;

  localparam int FLAG_EN     = 0;
  localparam int FLAG_TO_DEV = 1;
  localparam int FLAG_TC     = 8;
  localparam int FLAG_MEMERR = 9;
  localparam int FLAG_ADRERR = 10;

  typedef enum logic [1:0] {
    IDX_MODE  = 2'd0,
    IDX_FLAGS = 2'd1,
    IDX_COUNT = 2'd2,
    IDX_ADDR  = 2'd3
  } reg_idx_e;

  // status bits wiped at the start of each request
  function automatic logic [DATA_W-1:0] wipe_status(logic [DATA_W-1:0] f);
    logic [DATA_W-1:0] r;
    r = f;
    r[FLAG_TC]     = 1'b0;
    r[FLAG_MEMERR] = 1'b0;
    r[FLAG_ADRERR] = 1'b0;
    return r;
  endfunction

  function automatic logic refuse(logic [DATA_W-1:0] f, logic to_dev);
    return !f[FLAG_EN] || (to_dev != f[FLAG_TO_DEV]);
  endfunction

  function automatic logic [DATA_W-1:0] clamp_len(logic [DATA_W-1:0] want,
                                                  logic [DATA_W-1:0] avail);
    return (want < avail) ? want : avail;
  endfunction
endpackage

// File: rtl/dma_cc_decode.sv
`timescale 1ns/1ps
module dma_cc_decode #(
  parameter int ADDR_W  = 10,
  parameter int NUM_CH  = 8,
  parameter int CH_BASE = 'h100,
  parameter int ERR_OFS = 'h200,
  localparam int CH_BITS = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               ch_hit,
  output logic [CH_BITS-1:0] ch_sel,
  output logic [1:0]         idx_sel,
  output logic               err_hit
);
  localparam int WIN_HI = CH_BASE + NUM_CH * 32;

  always_comb begin
    ch_hit  = ({1'b0, addr} >= (ADDR_W+1)'(CH_BASE)) &&
              ({1'b0, addr} <  (ADDR_W+1)'(WIN_HI));
    ch_sel  = addr[5 +: CH_BITS];
    idx_sel = addr[4:3];
    err_hit = (addr[ADDR_W-1:2] == (ADDR_W-2)'(ERR_OFS >> 2));
  end
endmodule

// File: rtl/dma_cc_check.sv
`timescale 1ns/1ps
module dma_cc_check
  import dma_cc_pkg::*;
(
  input  logic [DATA_W-1:0] flags,
  input  logic [DATA_W-1:0] count,
  input  logic              to_dev,
  input  logic [DATA_W-1:0] want,
  output logic              err,
  output logic [DATA_W-1:0] grant,
  output logic [DATA_W-1:0] flags_nx,
  output logic [DATA_W-1:0] count_nx
);
  always_comb begin
    err      = refuse(flags, to_dev);
    flags_nx = wipe_status(flags);
    if (err) begin
      grant                 = '0;
      flags_nx[FLAG_MEMERR] = 1'b1;
      count_nx              = count;
    end else begin
      grant             = clamp_len(want, count);
      flags_nx[FLAG_TC] = 1'b1;
      count_nx          = count - grant;
    end
  end
endmodule

// File: rtl/dma_cc_channel.sv
`timescale 1ns/1ps
module dma_cc_channel
  import dma_cc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic [1:0]            host_idx,
  input  logic [DATA_W-1:0]     host_wdata,
  input  logic                  req_upd,
  input  logic [DATA_W-1:0]     upd_flags,
  input  logic [DATA_W-1:0]     upd_count,
  output logic [3:0][DATA_W-1:0] regs_o
);
  for (genvar r = 0; r < 4; r++) begin : g_reg
    localparam logic UPD_OWNED = (r == IDX_FLAGS) || (r == IDX_COUNT);
    logic              req_take;
    logic [DATA_W-1:0] req_val;
    assign req_take = req_upd && UPD_OWNED;
    assign req_val  = (r == IDX_FLAGS) ? upd_flags : upd_count;

    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_o[r] <= '0;
      else if (req_take)
        regs_o[r] <= req_val;
      else if (host_we && (host_idx == 2'(r)))
        regs_o[r] <= host_wdata;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
  import dma_cc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 16,
  localparam int CH_BITS = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               req_valid,
  input  logic [CH_BITS-1:0] req_ch,
  input  logic               req_to_dev,
  input  logic [LEN_W-1:0]   req_len,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [LEN_W-1:0]   rsp_len,
  output logic [DATA_W-1:0]  rsp_addr
);
  logic               dec_ch_hit, dec_err_hit;
  logic [CH_BITS-1:0] dec_ch;
  logic [1:0]         dec_idx;

  dma_cc_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr   (host_addr),
    .ch_hit (dec_ch_hit),
    .ch_sel (dec_ch),
    .idx_sel(dec_idx),
    .err_hit(dec_err_hit)
  );

  logic [NUM_CH-1:0][3:0][DATA_W-1:0] ch_regs;
  logic [3:0][DATA_W-1:0]             sel_regs;
  logic [NUM_CH-1:0]                  err_src_q;

  // named events for the checker
  logic              req_err_w;
  logic [DATA_W-1:0] req_grant_w;
  logic [DATA_W-1:0] flags_nx_w;
  logic [DATA_W-1:0] count_nx_w;
  logic              host_wr_hit_w;

  assign sel_regs      = ch_regs[req_ch];
  assign host_wr_hit_w = host_sel && host_wr && dec_ch_hit;

  dma_cc_check u_chk (
    .flags   (sel_regs[IDX_FLAGS]),
    .count   (sel_regs[IDX_COUNT]),
    .to_dev  (req_to_dev),
    .want    (DATA_W'(req_len)),
    .err     (req_err_w),
    .grant   (req_grant_w),
    .flags_nx(flags_nx_w),
    .count_nx(count_nx_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_cc_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (host_wr_hit_w && (dec_ch == CH_BITS'(c))),
      .host_idx  (dec_idx),
      .host_wdata(host_wdata),
      .req_upd   (req_valid && (req_ch == CH_BITS'(c))),
      .upd_flags (flags_nx_w),
      .upd_count (count_nx_w),
      .regs_o    (ch_regs[c])
    );
  end

  always_comb begin
    host_rdata = '0;
    if (host_sel && !host_wr) begin
      if (dec_ch_hit)
        host_rdata = ch_regs[dec_ch][dec_idx];
      else if (dec_err_hit)
        host_rdata = DATA_W'(err_src_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_len   <= '0;
      rsp_addr  <= '0;
      err_src_q <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_err  <= req_err_w;
        rsp_len  <= LEN_W'(req_grant_w);
        rsp_addr <= req_err_w ? '0 : sel_regs[IDX_ADDR];
        if (req_err_w)
          err_src_q[req_ch] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_cc_checker.sv
`timescale 1ns/1ps
module dma_cc_checker #(
  parameter int NUM_CH = 8,
  parameter int LEN_W  = 16,
  localparam int CH_BITS = $clog2(NUM_CH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [CH_BITS-1:0] req_ch,
  input logic [LEN_W-1:0]   req_len,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [LEN_W-1:0]   rsp_len,
  input logic [NUM_CH-1:0]  err_src_q,
  input logic               req_err_w,
  input logic [31:0]        req_grant_w,
  input logic [31:0]        sel_count
);
  assert_rsp_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  assert_refusal_grants_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_len == '0));

  assert_grant_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_err_w) |-> (req_grant_w <= 32'(req_len) && req_grant_w <= sel_count));

  assert_err_src_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_src_q & $past(err_src_q)) == $past(err_src_q));

  assert_refusal_marks_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> err_src_q[$past(req_ch)]);
endmodule

bind dma_chan_ctrl dma_cc_checker #(.NUM_CH(NUM_CH), .LEN_W(LEN_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ch     (req_ch),
  .req_len    (req_len),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_len    (rsp_len),
  .err_src_q  (err_src_q),
  .req_err_w  (req_err_w),
  .req_grant_w(req_grant_w),
  .sel_count  (sel_regs[2])
);

// File: tb/dma_chan_ctrl_bench.sv
`timescale 1ns/1ps
module dma_chan_ctrl_bench;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        req_valid = 1'b0, req_to_dev = 1'b0;
  logic [2:0]  req_ch = '0;
  logic [15:0] req_len = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_len;
  logic [31:0] rsp_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_reg [NCH][4];
  logic [7:0]  m_src;

  always #10 clk = ~clk;

  dma_chan_ctrl u_dma_chan_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int offs(int c, int idx);
    return 'h100 + c * 'h20 + idx * 8;
  endfunction

  task automatic host_write(int a, logic [31:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = 10'(a); host_wdata = d;
    @(posedge clk);
    if (a >= 'h100 && a < 'h200) m_reg[(a >> 5) & 7][(a >> 3) & 3] = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic host_read(int a, output logic [31:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = 10'(a);
    #1 d = host_rdata;
    host_sel = 0;
  endtask

  function automatic logic [31:0] model_read(int a);
    if (a >= 'h100 && a < 'h200) return m_reg[(a >> 5) & 7][(a >> 3) & 3];
    if ((a & ~3) == 'h200) return {24'd0, m_src};
    return 32'd0;
  endfunction

  // expected outcome and model update for one request
  task automatic model_req(int c, bit to_dev, int len,
                           output bit err, output int grant, output logic [31:0] adr);
    logic [31:0] f;
    f = m_reg[c][1];
    f[10:8] = 3'b000;
    if (f[0] == 1'b0 || f[1] != to_dev) begin
      err = 1; grant = 0; adr = 0;
      f[9] = 1'b1;
      m_src[c] = 1'b1;
    end else begin
      err = 0;
      grant = (len < m_reg[c][2]) ? len : int'(m_reg[c][2]);
      adr = m_reg[c][3];
      f[8] = 1'b1;
      m_reg[c][2] = m_reg[c][2] - 32'(grant);
    end
    m_reg[c][1] = f;
  endtask

  task automatic do_req(int c, bit to_dev, int len, string tag);
    bit e; int g; logic [31:0] a;
    model_req(c, to_dev, len, e, g, a);
    @(negedge clk);
    req_valid = 1; req_ch = 3'(c); req_to_dev = to_dev; req_len = 16'(len);
    @(posedge clk);
    #1;
    chk({tag, " R4 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " R6/R8 rsp_err"}, {31'd0, rsp_err}, {31'd0, e});
    chk({tag, " R8 rsp_len"}, {16'd0, rsp_len}, 32'(g));
    chk({tag, " R8 rsp_addr"}, rsp_addr, a);
    @(negedge clk);
    req_valid = 0;
    @(posedge clk);
    #1 chk({tag, " R4 one-cycle pulse"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic read_chk(int a, string tag);
    logic [31:0] d;
    host_read(a, d);
    chk(tag, d, model_read(a));
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_0042));
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 4; i++) m_reg[c][i] = 0;
    m_src = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    read_chk('h200, "R1 err source");
    for (int c = 0; c < NCH; c++) read_chk(offs(c, 1), "R1 flags");

    // R2 full register map
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 4; i++) host_write(offs(c, i), {8'(c), 8'(i), 16'hA5C3 ^ 16'(c * 7 + i)});
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 4; i++) read_chk(offs(c, i), "R2 readback");
    host_read(offs(5, 2) + 4, d);
    chk("R2 low bits ignored", d, m_reg[5][2]);

    // R3 unmapped and read-only
    host_write('h000, 32'hFFFF_FFFF);
    host_write('h0F8, 32'hFFFF_FFFF);
    host_write('h208, 32'hFFFF_FFFF);
    host_write('h200, 32'hFFFF_FFFF);
    read_chk('h000, "R3 unmapped 0x000");
    read_chk('h0F8, "R3 unmapped 0x0F8");
    read_chk('h208, "R3 unmapped 0x208");
    read_chk('h200, "R3 err source read-only");
    read_chk(offs(0, 0), "R3 channel 0 untouched");
    read_chk(offs(7, 3), "R3 channel 7 untouched");

    // R6/R7 disabled channel, with stale status bits to be wiped (R5)
    host_write(offs(2, 1), 32'h0000_F702);
    host_write(offs(2, 2), 32'd500);
    do_req(2, 1, 40, "disabled");
    read_chk(offs(2, 1), "R5/R6 flags after refusal");
    read_chk(offs(2, 2), "R6 count unchanged");
    read_chk('h200, "R7 err source bit 2");
    // direction mismatch
    host_write(offs(4, 1), 32'h0000_0001);
    do_req(4, 1, 10, "mismatch");
    read_chk('h200, "R7 err source bits 2,4");

    // R8 clamp by length, then by count, address kept
    host_write(offs(3, 1), 32'hAB00_0703);
    host_write(offs(3, 2), 32'd100);
    host_write(offs(3, 3), 32'h8000_1000);
    do_req(3, 1, 30, "clamp-len");
    read_chk(offs(3, 2), "R8 count 70");
    read_chk(offs(3, 1), "R5/R8 flags keep upper");
    do_req(3, 1, 200, "clamp-count");
    read_chk(offs(3, 2), "R8 count 0");
    read_chk(offs(3, 3), "R8 address unchanged");
    // R9 zero count
    do_req(3, 1, 5, "R9 zero count");
    read_chk(offs(3, 1), "R9 terminal flag");
    read_chk('h200, "R7 sticky after success");

    // R10 collision: flags/count write dropped, address write kept
    host_write(offs(6, 1), 32'h0000_0001);
    host_write(offs(6, 2), 32'd100);
    begin
      bit e; int g; logic [31:0] a;
      model_req(6, 0, 10, e, g, a);
      @(negedge clk);
      req_valid = 1; req_ch = 3'd6; req_to_dev = 0; req_len = 16'd10;
      host_sel = 1; host_wr = 1; host_addr = 10'(offs(6, 2)); host_wdata = 32'd5;
      @(posedge clk);
      #1 chk("R10 grant", {16'd0, rsp_len}, 32'(g));
      @(negedge clk);
      host_addr = 10'(offs(6, 3)); host_wdata = 32'h1234_5678; req_valid = 1;
      model_req(6, 0, 10, e, g, a);
      m_reg[6][3] = 32'h1234_5678;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0; host_sel = 0; host_wr = 0;
    end
    read_chk(offs(6, 2), "R10 count write dropped");
    read_chk(offs(6, 3), "R10 address write kept");

    // random mix
    for (int n = 0; n < 500; n++) begin
      int c, op;
      c  = $urandom % NCH;
      op = $urandom % 4;
      if (op == 0) begin
        int i; logic [31:0] v;
        i = $urandom % 4;
        v = $urandom;
        if (i == 1) v[1:0] = 2'($urandom % 4);
        if (i == 2 && ($urandom % 2)) v = $urandom % 300;
        host_write(offs(c, i), v);
      end else if (op == 3) begin
        read_chk(offs(c, $urandom % 4), "R2/R5/R8 random readback");
      end else begin
        do_req(c, 1'($urandom % 2), $urandom % 400, "random");
      end
    end
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 4; i++) read_chk(offs(c, i), "R8 final state");
    read_chk('h200, "R7 final err source");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule